// File: doc/BRIEF.md
# DMA Channel Request Latch and Priority Arbiter

This block sits in front of the shared bus port of a multi-channel DMA engine. For every channel it holds one pending-request bit. Three sources can set that bit: a software trigger bit, one selected peripheral trigger line, and, on the lowest event-capable channels only, an event input. While a request is already pending, further triggers for that channel add nothing. The same event inputs can also hold a channel back (suspend), release it (resume), or waive the next suspend that a finished descriptor unit would otherwise cause.

Once per beat the arbiter picks one eligible channel. A channel is eligible when it is pending, enabled and not suspended. The pick goes to the highest priority level. Within a level it rotates round-robin. The choice is held as a registered one-hot grant together with its index. The data path reports the end of each beat, which opens the next arbitration. It also reports the end of the unit selected by the channel's trigger action, which clears that channel's pending bit.

Top module: `dma_req_arbiter`

## Requirements
- R1: On a clock edge with `rst` high, all pending bits, all suspend flags and the grant are cleared, and `grant_valid` is 0.
- R2: A pulse on `sw_trig[c]` sets `pending[c]`. A further trigger on a channel whose bit is already set does not cause a second service: one unit completion clears the bit and no grant for that channel follows.
- R3: The peripheral select of channel c (4 bits at `periph_sel[4c+3:4c]`) holds 0 for no line, or k to listen to `periph_trig[k-1]`. A pulse on the selected line sets `pending[c]`. Lines that no channel selects change nothing. On channels 0 to 3, the event action code (3 bits at `ev_act[3c+2:3c]`) 1 means a pulse on `ev_in[c]` sets `pending[c]`. Code 0 means the event is ignored.
- R4: Event action 2 accepts the channel's peripheral trigger only in a cycle where `ev_in[c]` is high. Event action 3 accepts exactly one peripheral trigger after each `ev_in[c]` pulse.
- R5: Event action 4 sets `suspended[c]`. Action 5 or `sw_resume[c]` clears it. A suspended channel, or one with `ch_enable[c]` low, keeps its pending bit but is never granted until it is released.
- R6: The 2-bit priority of channel c is at `ch_prio[2c+1:2c]`, and 3 is the highest. A new grant always goes to a channel of the highest level among eligible channels.
- R7: Within one level the grant goes to the first eligible channel after the one last granted at that level, counting upward and wrapping. After reset, the search at each level starts at channel 0.
- R8: `grant` is one-hot and matches `grant_idx`. A grant holds until `beat_done`. Arbitration then runs in that same edge, so an idle or newly eligible channel is granted one cycle after its pending bit is set.
- R9: `beat_done` together with `unit_done` clears the granted channel's pending bit. A trigger for that channel in the same cycle is dropped.
- R10: A unit completion with `done_suspend` high suspends the granted channel. The exception is a channel that has seen event action 6: the suspend is skipped once and the skip is then used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_trig | input | NUM_CH | Software trigger pulse per channel |
| sw_resume | input | NUM_CH | Software resume pulse per channel |
| periph_trig | input | NUM_PERIPH | Peripheral trigger lines |
| periph_sel | input | NUM_CH*SEL_W | Per-channel peripheral line select, 0 = none |
| ev_in | input | NUM_EVCH | Event input strobes for the low channels |
| ev_act | input | NUM_EVCH*3 | Per-event-channel action code |
| ch_enable | input | NUM_CH | Channel enable |
| ch_prio | input | NUM_CH*2 | Per-channel priority level |
| beat_done | input | 1 | Granted beat finished, re-arbitrate |
| unit_done | input | 1 | Trigger-action unit of the granted channel finished |
| done_suspend | input | 1 | Finished unit asks to suspend the channel |
| grant | output | NUM_CH | One-hot bus grant |
| grant_valid | output | 1 | A grant is active |
| grant_idx | output | IDX_W | Index of the granted channel |
| pending | output | NUM_CH | Pending-request bits |
| suspended | output | NUM_CH | Suspend flags |

## Verification
The grant order is checked over sixteen priority patterns, each with its own set of pending channels. Each order is compared against an arithmetic model of level-first, rotate-within-level selection, which separates level handling from index order. A three-channel same-level sequence re-triggers a low-index channel. It shows rotation, not fixed index priority, because the rotating pick skips that channel in favour of a higher index. Trigger-source tests use disabled channels, so the pending bits can be read back without grants consuming them. The gated and armed event modes are driven with and without the event line. Suspend, resume and skip are run through event codes, software resume and descriptor-driven suspend. A hold test puts a higher-priority request against an unfinished beat.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int PRIO_W  = 2;
    localparam int NUM_LVL = 4;
    localparam int ACT_W   = 3;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [ACT_W-1:0] {
        EV_NONE   = 3'd0,
        EV_TRIG   = 3'd1,
        EV_GATE   = 3'd2,
        EV_ARM    = 3'd3,
        EV_SUSP   = 3'd4,
        EV_RESUME = 3'd5,
        EV_SKIP   = 3'd6
    } ev_act_e;

    typedef struct packed {
        logic pend;
        logic susp;
        logic skip;
        logic armed;
    } ch_state_t;

    function automatic ev_act_e decode_act(input logic [ACT_W-1:0] code);
        case (code)
            3'd1:    return EV_TRIG;
            3'd2:    return EV_GATE;
            3'd3:    return EV_ARM;
            3'd4:    return EV_SUSP;
            3'd5:    return EV_RESUME;
            3'd6:    return EV_SKIP;
            default: return EV_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_trig_latch.sv
module dma_trig_latch
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH     = 12,
    parameter int NUM_EVCH   = 4,
    parameter int NUM_PERIPH = 8,
    parameter int SEL_W      = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CH-1:0]         sw_trig,
    input  logic [NUM_CH-1:0]         sw_resume,
    input  logic [NUM_PERIPH-1:0]     periph_trig,
    input  logic [NUM_CH*SEL_W-1:0]   periph_sel,
    input  logic [NUM_EVCH-1:0]       ev_in,
    input  logic [NUM_EVCH*ACT_W-1:0] ev_act,
    input  logic [NUM_CH-1:0]         clr_mask,
    input  logic [NUM_CH-1:0]         susp_mask,
    output logic [NUM_CH-1:0]         pending,
    output logic [NUM_CH-1:0]         suspended
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_state_t  st, st_n;
        logic       ev;
        ev_act_e    act;
        logic       p_line;
        logic       gate_ok;
        logic [SEL_W-1:0] sel;

        assign sel = periph_sel[c*SEL_W +: SEL_W];

        if (c < NUM_EVCH) begin : g_ev
            assign ev  = ev_in[c];
            assign act = decode_act(ev_act[c*ACT_W +: ACT_W]);
        end else begin : g_noev
            assign ev  = 1'b0;
            assign act = EV_NONE;
        end

        always_comb begin
            p_line = 1'b0;
            for (int i = 0; i < NUM_PERIPH; i++) begin
                if (sel == SEL_W'(i + 1)) p_line = periph_trig[i];
            end
        end

        always_comb begin
            case (act)
                EV_GATE: gate_ok = ev;
                EV_ARM:  gate_ok = st.armed;
                default: gate_ok = 1'b1;
            endcase
        end

        always_comb begin
            st_n = st;
            // a request already pending absorbs every new trigger
            if (clr_mask[c])
                st_n.pend = 1'b0;
            else if (sw_trig[c] || (p_line && gate_ok) || (ev && act == EV_TRIG))
                st_n.pend = 1'b1;

            if (act == EV_ARM)
                st_n.armed = (st.armed && !p_line) || ev;
            else
                st_n.armed = 1'b0;

            if (susp_mask[c] && !st.skip) st_n.susp = 1'b1;
            if (ev && act == EV_SUSP)     st_n.susp = 1'b1;
            if (sw_resume[c] || (ev && act == EV_RESUME)) st_n.susp = 1'b0;

            st_n.skip = (st.skip && !susp_mask[c]) || (ev && act == EV_SKIP);
        end

        always_ff @(posedge clk) begin
            if (rst) st <= '0;
            else     st <= st_n;
        end

        assign pending[c]   = st.pend;
        assign suspended[c] = st.susp;
    end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        eligible,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    input  logic                     take,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx,
    output logic [NUM_CH-1:0]        win_onehot
);

    prio_t            prio [NUM_CH];
    logic [NUM_LVL-1:0] lvl_any;
    prio_t            top_lvl;
    logic [IDX_W-1:0] last [NUM_LVL];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_prio
        assign prio[c] = prio_flat[c*PRIO_W +: PRIO_W];
    end

    always_comb begin
        lvl_any = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (eligible[c]) lvl_any[prio[c]] = 1'b1;
        end
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_any[l]) top_lvl = PRIO_W'(l);
        end
    end

    // search upward from the last winner of the top level; nearest wins
    always_comb begin
        win_idx = '0;
        for (int k = NUM_CH; k >= 1; k--) begin
            int pos;
            pos = int'(last[top_lvl]) + k;
            if (pos >= NUM_CH) pos = pos - NUM_CH;
            if (eligible[pos] && prio[pos] == top_lvl) win_idx = IDX_W'(pos);
        end
    end

    assign win_valid  = |eligible;
    assign win_onehot = win_valid ? (NUM_CH'(1) << win_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NUM_LVL; l++) last[l] <= IDX_W'(NUM_CH - 1);
        end else if (take) begin
            last[top_lvl] <= win_idx;
        end
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter  int NUM_CH     = 12,
    parameter  int NUM_EVCH   = 4,
    parameter  int NUM_PERIPH = 8,
    localparam int SEL_W      = $clog2(NUM_PERIPH + 1),
    localparam int IDX_W      = $clog2(NUM_CH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CH-1:0]           sw_trig,
    input  logic [NUM_CH-1:0]           sw_resume,
    input  logic [NUM_PERIPH-1:0]       periph_trig,
    input  logic [NUM_CH*SEL_W-1:0]     periph_sel,
    input  logic [NUM_EVCH-1:0]         ev_in,
    input  logic [NUM_EVCH*ACT_W-1:0]   ev_act,
    input  logic [NUM_CH-1:0]           ch_enable,
    input  logic [NUM_CH*PRIO_W-1:0]    ch_prio,
    input  logic                        beat_done,
    input  logic                        unit_done,
    input  logic                        done_suspend,
    output logic [NUM_CH-1:0]           grant,
    output logic                        grant_valid,
    output logic [IDX_W-1:0]            grant_idx,
    output logic [NUM_CH-1:0]           pending,
    output logic [NUM_CH-1:0]           suspended
);

    logic              advance;
    logic              finish;
    logic [NUM_CH-1:0] clr_mask;
    logic [NUM_CH-1:0] susp_mask;
    logic [NUM_CH-1:0] eligible;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [NUM_CH-1:0] win_onehot;

    assign finish    = grant_valid && beat_done && unit_done;
    assign clr_mask  = finish ? grant : '0;
    assign susp_mask = (finish && done_suspend) ? grant : '0;
    assign advance   = !grant_valid || beat_done;
    assign eligible  = pending & ch_enable & ~suspended & ~clr_mask & ~susp_mask;

    dma_trig_latch #(
        .NUM_CH(NUM_CH), .NUM_EVCH(NUM_EVCH),
        .NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)
    ) u_latch (
        .clk(clk), .rst(rst),
        .sw_trig(sw_trig), .sw_resume(sw_resume),
        .periph_trig(periph_trig), .periph_sel(periph_sel),
        .ev_in(ev_in), .ev_act(ev_act),
        .clr_mask(clr_mask), .susp_mask(susp_mask),
        .pending(pending), .suspended(suspended)
    );

    dma_prio_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst(rst),
        .eligible(eligible), .prio_flat(ch_prio),
        .take(advance && win_valid),
        .win_valid(win_valid), .win_idx(win_idx), .win_onehot(win_onehot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant       <= '0;
            grant_valid <= 1'b0;
            grant_idx   <= '0;
        end else if (advance) begin
            grant       <= win_onehot;
            grant_valid <= win_valid;
            grant_idx   <= win_idx;
        end
    end

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
    parameter int NUM_CH = 12,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              beat_done,
    input logic              unit_done,
    input logic [NUM_CH-1:0] grant,
    input logic              grant_valid,
    input logic [IDX_W-1:0]  grant_idx,
    input logic [NUM_CH-1:0] pending,
    input logic [NUM_CH-1:0] suspended,
    input logic [NUM_CH-1:0] ch_enable
);

    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] free_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        pend_q <= pending;
        free_q <= ch_enable & ~suspended;
        idx_q  <= grant_idx;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (grant == '0 && !grant_valid && pending == '0 && suspended == '0));

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (grant_valid == (grant != '0)));

    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !beat_done) |=> ($stable(grant_idx) && grant_valid));

    // R9
    serviced_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && beat_done && unit_done) |=> !pending[idx_q]);

    // R5
    grant_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid || beat_done) |=> (!grant_valid || (pend_q[grant_idx] && free_q[grant_idx])));

endmodule

bind dma_req_arbiter dma_arb_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;

    localparam int N  = 12;
    localparam int NE = 4;
    localparam int NP = 8;
    localparam int SW = 4;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  sw_trig = '0, sw_resume = '0, ch_enable = '0;
    logic [NP-1:0] periph_trig = '0;
    logic [N*SW-1:0] periph_sel = '0;
    logic [NE-1:0] ev_in = '0;
    logic [NE*3-1:0] ev_act = '0;
    logic [N*2-1:0] ch_prio = '0;
    logic          beat_done = 1'b0, unit_done = 1'b0, done_suspend = 1'b0;
    logic [N-1:0]  grant, pending, suspended;
    logic          grant_valid;
    logic [IW-1:0] grant_idx;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int bprio [N];
    int blast [4];

    always #4 clk = ~clk;

    dma_req_arbiter #(.NUM_CH(N), .NUM_EVCH(NE), .NUM_PERIPH(NP)) i_dma_req_arbiter (
        .clk(clk), .rst(rst), .sw_trig(sw_trig), .sw_resume(sw_resume),
        .periph_trig(periph_trig), .periph_sel(periph_sel), .ev_in(ev_in), .ev_act(ev_act),
        .ch_enable(ch_enable), .ch_prio(ch_prio), .beat_done(beat_done), .unit_done(unit_done),
        .done_suspend(done_suspend), .grant(grant), .grant_valid(grant_valid),
        .grant_idx(grant_idx), .pending(pending), .suspended(suspended)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_prio();
        for (int c = 0; c < N; c++) ch_prio[c*2 +: 2] = 2'(bprio[c]);
    endtask

    task automatic do_reset();
        rst = 1'b1; sw_trig = '0; sw_resume = '0; ch_enable = '0; periph_trig = '0;
        periph_sel = '0; ev_in = '0; ev_act = '0; ch_prio = '0;
        beat_done = 0; unit_done = 0; done_suspend = 0;
        for (int c = 0; c < N; c++) bprio[c] = 0;
        for (int l = 0; l < 4; l++) blast[l] = N - 1;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic pulse_sw(input logic [N-1:0] m);
        sw_trig = m; step(); sw_trig = '0;
    endtask

    task automatic finish_unit(input logic sus);
        beat_done = 1; unit_done = 1; done_suspend = sus;
        step();
        beat_done = 0; unit_done = 0; done_suspend = 0;
    endtask

    function automatic int model_pick(input logic [N-1:0] pend);
        for (int l = 3; l >= 0; l--) begin
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (blast[l] + k) % N;
                if (pend[c] && bprio[c] == l) return c;
            end
        end
        return -1;
    endfunction

    task automatic drain(input logic [N-1:0] mask);
        logic [N-1:0] mp;
        mp = mask;
        for (int n = 0; n < $countones(mask); n++) begin
            int e;
            if (!grant_valid) step();
            e = model_pick(mp);
            check("R6/R7 grant order", int'(grant_idx), e);
            finish_unit(1'b0);
            mp[e] = 1'b0;
            blast[bprio[e]] = e;
        end
        check("R8 idle after drain", int'(grant_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1
        do_reset();
        check("R1 pending", int'(pending), 0);
        check("R1 suspended", int'(suspended), 0);
        check("R1 grant_valid", int'(grant_valid), 0);
        check("R1 grant", int'(grant), 0);

        // R2 repeat trigger while pending is absorbed
        ch_enable = '1;
        pulse_sw(12'h008);
        check("R2 pending set", int'(pending[3]), 1);
        pulse_sw(12'h008);
        check("R2 grant idx", int'(grant_idx), 3);
        check("R8 one-hot", int'(grant), 8);
        check("R2 still pending", int'(pending[3]), 1);
        finish_unit(1'b0);
        check("R2 cleared once", int'(pending[3]), 0);
        check("R2 no second grant", int'(grant_valid), 0);

        // R9 clear wins against same-cycle trigger
        pulse_sw(12'h008); step();
        sw_trig = 12'h008; finish_unit(1'b0); sw_trig = '0;
        check("R9 clear wins", int'(pending[3]), 0);

        // R3 peripheral and event trigger sources
        do_reset();
        periph_sel[7*SW +: SW] = 4'd3;
        periph_trig[2] = 1; step(); periph_trig = '0;
        check("R3 periph line", int'(pending), 12'h080);
        periph_trig[5] = 1; step(); periph_trig = '0;
        check("R3 unused line", int'(pending), 12'h080);
        ev_act[1*3 +: 3] = 3'd1;
        ev_in[1] = 1; step(); ev_in = '0;
        check("R3 event trigger", int'(pending), 12'h082);
        ev_in[3] = 1; step(); ev_in = '0;
        check("R3 event action none", int'(pending), 12'h082);

        // R4 gated and armed peripheral triggers
        do_reset();
        periph_sel[0 +: SW] = 4'd1; ev_act[0 +: 3] = 3'd2;
        periph_trig[0] = 1; step(); periph_trig = '0;
        check("R4 gate closed", int'(pending[0]), 0);
        periph_trig[0] = 1; ev_in[0] = 1; step(); periph_trig = '0; ev_in = '0;
        check("R4 gate open", int'(pending[0]), 1);
        periph_sel[2*SW +: SW] = 4'd2; ev_act[2*3 +: 3] = 3'd3;
        periph_trig[1] = 1; step(); periph_trig = '0;
        check("R4 unarmed", int'(pending[2]), 0);
        ev_in[2] = 1; step(); ev_in = '0;
        periph_trig[1] = 1; step(); periph_trig = '0;
        check("R4 armed", int'(pending[2]), 1);
        ch_enable = 12'h004; step();
        check("R4 grant armed ch", int'(grant_idx), 2);
        finish_unit(1'b0); ch_enable = '0;
        periph_trig[1] = 1; step(); periph_trig = '0;
        check("R4 arm consumed", int'(pending[2]), 0);

        // R5 suspend, resume, disable
        do_reset();
        ch_enable = '1;
        ev_act[1*3 +: 3] = 3'd4; ev_in[1] = 1; step(); ev_in = '0;
        check("R5 suspended", int'(suspended[1]), 1);
        pulse_sw(12'h002); step(); step();
        check("R5 no grant suspended", int'(grant_valid), 0);
        check("R5 keeps pending", int'(pending[1]), 1);
        ev_act[1*3 +: 3] = 3'd5; ev_in[1] = 1; step(); ev_in = '0;
        check("R5 resumed", int'(suspended[1]), 0);
        step();
        check("R5 grant after resume", int'(grant_idx), 1);
        check("R5 grant valid", int'(grant_valid), 1);
        finish_unit(1'b0);
        ch_enable[6] = 0;
        pulse_sw(12'h040); step(); step();
        check("R5 disabled no grant", int'(grant_valid), 0);
        check("R5 disabled pending", int'(pending[6]), 1);
        ch_enable[6] = 1; step();
        check("R5 enabled grant", int'(grant_idx), 6);
        finish_unit(1'b0);
        pulse_sw(12'h200); step();
        check("R10 grant ch9", int'(grant_idx), 9);
        finish_unit(1'b1);
        check("R10 done suspend", int'(suspended[9]), 1);
        pulse_sw(12'h200); step(); step();
        check("R5 suspended by unit", int'(grant_valid), 0);
        sw_resume[9] = 1; step(); sw_resume = '0;
        step();
        check("R5 sw resume grant", int'(grant_idx), 9);
        finish_unit(1'b0);

        // R10 skip next suspend
        do_reset();
        ch_enable = '1;
        ev_act[0 +: 3] = 3'd6; ev_in[0] = 1; step(); ev_in = '0;
        pulse_sw(12'h001); step();
        finish_unit(1'b1);
        check("R10 skipped", int'(suspended[0]), 0);
        pulse_sw(12'h001); step();
        finish_unit(1'b1);
        check("R10 skip used up", int'(suspended[0]), 1);

        // R8 grant held until beat end
        do_reset();
        ch_enable = '1; bprio[8] = 3; set_prio();
        pulse_sw(12'h010); step();
        check("R8 first grant", int'(grant_idx), 4);
        pulse_sw(12'h100); step(); step();
        check("R8 held", int'(grant_idx), 4);
        beat_done = 1; step(); beat_done = 0;
        check("R8 rearb to high", int'(grant_idx), 8);
        check("R8 low still pending", int'(pending[4]), 1);
        finish_unit(1'b0);
        check("R8 back to low", int'(grant_idx), 4);
        finish_unit(1'b0);

        // R7 rotation within a level
        do_reset();
        ch_enable = '1;
        for (int c = 0; c < N; c++) bprio[c] = 1;
        set_prio();
        pulse_sw(12'h224); step();
        check("R7 first", int'(grant_idx), 2);
        finish_unit(1'b0);
        check("R7 second", int'(grant_idx), 5);
        pulse_sw(12'h004);
        finish_unit(1'b0);
        check("R7 rotates past 2", int'(grant_idx), 9);
        finish_unit(1'b0);
        check("R7 wraps to 2", int'(grant_idx), 2);
        finish_unit(1'b0);

        // R6/R7 sweep of priority patterns
        for (int p = 0; p < 16; p++) begin
            logic [N-1:0] m;
            do_reset();
            ch_enable = '1;
            for (int c = 0; c < N; c++) bprio[c] = (c * (p + 1) + p / 4 + (c >> 1) * p) % 4;
            set_prio();
            m = (p == 0) ? '1 : N'(((12'hA5C * (p + 3)) ^ (p * 97)) | (1 << (p % N)));
            pulse_sw(m);
            drain(m);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule